// File: doc/BRIEF.md
# POST Code Seven-Segment Display Driver

This block snoops host I/O write strobes and keeps the last byte written to I/O address 0x80, the port where firmware posts its boot progress codes. It shows that byte as two hexadecimal digits on a display that shares one seven-line segment bus. The high and low nibbles take turns on the bus at a rate derived from the input clock, and a pair of digit selects says which digit is lit.

The display is on when either a power-on strap input or a register enable bit is set. A route select picks which of two output groups carries the display. Group 0, the printer-data group, is the default. The other group is driven low. A mode input shows a supplied temperature byte in place of the captured code. Host bus cycle decoding, pin muxing and pad drive sit outside this block.

Top module: `post_code_display`

## Requirements
- R1: An I/O write strobe with address exactly 0x80 stores the data byte. The stored byte appears on the display from the cycle after the strobe's clock edge.
- R2: A write strobe to any other address, including 0x81 and 0x0180, leaves the stored byte unchanged.
- R3: Each nibble is shown as an active-high pattern with bit 0 = segment a up to bit 6 = segment g. The codes are 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 b=7C C=39 d=5E E=79 F=71 (hex).
- R4: The high nibble is shown with digit select 2'b10 and the low nibble with 2'b01. The two alternate, and each phase lasts CLK_HZ/SWITCH_HZ clock cycles.
- R5: The first cycle of every phase has both digit selects low. The two selects are never high together, and a lit select never changes directly to the other one.
- R6: The display is enabled when strap_en or reg_en is 1. While both are 0, every segment and digit-select output is 0. Writes are still captured.
- R7: route_sel=0 drives group 0 (printer-data group) and holds group 1 at 0. route_sel=1 does the reverse.
- R8: While temp_mode=1, temp_val is shown instead of the stored code.
- R9: After reset the stored byte is 0x00 and the first phase shows the high nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 16 | I/O write address |
| io_data | input | 8 | I/O write data |
| strap_en | input | 1 | Power-on strap enable |
| reg_en | input | 1 | Register enable bit |
| route_sel | input | 1 | 0 = printer-data group, 1 = alternate group |
| temp_mode | input | 1 | Show temp_val instead of the POST code |
| temp_val | input | 8 | Temperature byte |
| prn_seg | output | 7 | Group 0 segments a..g |
| prn_dig | output | 2 | Group 0 digit selects {high, low} |
| alt_seg | output | 7 | Group 1 segments a..g |
| alt_dig | output | 2 | Group 1 digit selects {high, low} |

## Verification
A corrupted stored byte shows as a wrong segment pattern on the very next lit phase. It is therefore visible within two phases of the write. A drifting scan counter shows as a phase length other than CLK_HZ/SWITCH_HZ or as a missing blank cycle, on the first phase boundary after the fault. Routing or enable faults show as activity on a group that must stay at zero, in the same cycle as the input change.

// File: rtl/post_code_pkg.sv
// Package: shared types and the hex-to-segment encoder for the POST display.
// Assumes active-high segments, bit 0 = segment a .. bit 6 = segment g.
package post_code_pkg;

    typedef logic [6:0] seg_t;

    // Map one nibble to its seven-segment pattern.
    function automatic seg_t hex_to_seg(input logic [3:0] nib);
        case (nib)
            4'h0: hex_to_seg = 7'h3F;
            4'h1: hex_to_seg = 7'h06;
            4'h2: hex_to_seg = 7'h5B;
            4'h3: hex_to_seg = 7'h4F;
            4'h4: hex_to_seg = 7'h66;
            4'h5: hex_to_seg = 7'h6D;
            4'h6: hex_to_seg = 7'h7D;
            4'h7: hex_to_seg = 7'h07;
            4'h8: hex_to_seg = 7'h7F;
            4'h9: hex_to_seg = 7'h6F;
            4'hA: hex_to_seg = 7'h77;
            4'hB: hex_to_seg = 7'h7C;
            4'hC: hex_to_seg = 7'h39;
            4'hD: hex_to_seg = 7'h5E;
            4'hE: hex_to_seg = 7'h79;
            default: hex_to_seg = 7'h71;
        endcase
    endfunction

endpackage

// File: rtl/post_code_latch.sv
// post_code_latch: holds the last byte written to the watched I/O port.
// Assumes io_wr is a single-cycle strobe qualified with a stable address.
module post_code_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    output logic [DATA_W-1:0] code_q
);

    logic hit;

    // Match the strobe against the watched port address.
    always_comb hit = io_wr && (io_addr == PORT_ADDR);

    // Store the data byte on a matching write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   code_q <= '0;
        else if (hit) code_q <= io_data;
    end

endmodule

// File: rtl/scan_timer.sv
// scan_timer: divides the clock into display phases and flags the first
// cycle of each phase as blank. Assumes CLK_HZ/SWITCH_HZ >= 2.
module scan_timer #(
    parameter int CLK_HZ    = 48_000_000,
    parameter int SWITCH_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_lo,
    output logic blank
);

    localparam int DIV = CLK_HZ / SWITCH_HZ;
    localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count cycles per phase, toggle the nibble and blank on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            phase_lo <= 1'b0;
            blank    <= 1'b1;
        end else if (cnt == LAST) begin
            cnt      <= '0;
            phase_lo <= ~phase_lo;
            blank    <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            blank    <= 1'b0;
        end
    end

endmodule

// File: rtl/route_out.sv
// route_out: drives one output group when it is enabled and selected,
// otherwise holds the group at zero.
module route_out #(
    parameter int GRP = 0
) (
    input  logic       en,
    input  logic       route_sel,
    input  logic [6:0] seg_in,
    input  logic [1:0] dig_in,
    output logic [6:0] seg_out,
    output logic [1:0] dig_out
);

    logic mine;

    // Gate the shared display onto this group only when it owns the route.
    always_comb begin
        mine    = en && (route_sel == 1'(GRP));
        seg_out = mine ? seg_in : '0;
        dig_out = mine ? dig_in : '0;
    end

endmodule

// File: rtl/post_code_display.sv
// post_code_display: captures the POST byte and scans it onto a shared
// segment bus, high nibble then low nibble, on one of two output groups.
// Assumes a synchronous active-low reset and CLK_HZ/SWITCH_HZ >= 2.
module post_code_display
    import post_code_pkg::*;
#(
    parameter int CLK_HZ    = 48_000_000,
    parameter int SWITCH_HZ = 1000,
    parameter logic [15:0] PORT_ADDR = 16'h0080
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [15:0] io_addr,
    input  logic [7:0] io_data,
    input  logic       strap_en,
    input  logic       reg_en,
    input  logic       route_sel,
    input  logic       temp_mode,
    input  logic [7:0] temp_val,
    output logic [6:0] prn_seg,
    output logic [1:0] prn_dig,
    output logic [6:0] alt_seg,
    output logic [1:0] alt_dig
);

    localparam int NGRP = 2;

    logic [7:0] code_q;
    logic       phase_lo;
    logic       blank;
    logic [7:0] shown;
    logic [3:0] nib;
    seg_t       seg_w;
    logic [1:0] dig_w;
    logic       en;
    logic [6:0] grp_seg [NGRP];
    logic [1:0] grp_dig [NGRP];

    post_code_latch #(.ADDR_W(16), .DATA_W(8), .PORT_ADDR(PORT_ADDR)) latch_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .code_q(code_q)
    );

    scan_timer #(.CLK_HZ(CLK_HZ), .SWITCH_HZ(SWITCH_HZ)) timer_i (
        .clk(clk), .rst_n(rst_n), .phase_lo(phase_lo), .blank(blank)
    );

    // Pick the byte and nibble on show, encode it and form the digit select.
    always_comb begin
        en    = strap_en || reg_en;
        shown = temp_mode ? temp_val : code_q;
        nib   = phase_lo ? shown[3:0] : shown[7:4];
        seg_w = hex_to_seg(nib);
        dig_w = blank ? 2'b00 : (phase_lo ? 2'b01 : 2'b10);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        route_out #(.GRP(g)) out_i (
            .en(en), .route_sel(route_sel), .seg_in(seg_w), .dig_in(dig_w),
            .seg_out(grp_seg[g]), .dig_out(grp_dig[g])
        );
    end

    // Map the group array onto the named output ports.
    always_comb begin
        prn_seg = grp_seg[0];
        prn_dig = grp_dig[0];
        alt_seg = grp_seg[1];
        alt_dig = grp_dig[1];
    end

endmodule

// File: rtl/post_code_display_chk.sv
// post_code_display_chk: port-level properties of the POST display,
// attached to every instance of the top through bind.
module post_code_display_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strap_en,
    input logic       reg_en,
    input logic       route_sel,
    input logic [6:0] prn_seg,
    input logic [1:0] prn_dig,
    input logic [6:0] alt_seg,
    input logic [1:0] alt_dig
);

    // R5
    digit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(prn_dig) && $onehot0(alt_dig));

    // R5
    prn_no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prn_dig != 2'b00) |=> (prn_dig == 2'b00 || prn_dig == $past(prn_dig)));

    // R5
    alt_no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_dig != 2'b00) |=> (alt_dig == 2'b00 || alt_dig == $past(alt_dig)));

    // R6
    disabled_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strap_en || reg_en) |-> (prn_seg == 0 && prn_dig == 0 && alt_seg == 0 && alt_dig == 0));

    // R7
    prn_route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route_sel |-> (prn_seg == 0 && prn_dig == 0));

    // R7
    alt_route_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !route_sel |-> (alt_seg == 0 && alt_dig == 0));

endmodule

bind post_code_display post_code_display_chk chk_i (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .reg_en(reg_en),
    .route_sel(route_sel), .prn_seg(prn_seg), .prn_dig(prn_dig),
    .alt_seg(alt_seg), .alt_dig(alt_dig)
);

// File: tb/post_code_display_tb_top.sv
// Scoreboard bench: the driver pushes the expected digit pair after each
// stimulus, the monitor pops it once both digits have been seen.
module post_code_display_tb_top;

    localparam int CLK_HZ    = 20_000;
    localparam int SWITCH_HZ = 1000;
    localparam int DIV       = CLK_HZ / SWITCH_HZ;

    typedef struct {
        logic [6:0] hi;
        logic [6:0] lo;
        logic       route;
        string      tag;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic io_wr = 0;
    logic [15:0] io_addr = 0;
    logic [7:0] io_data = 0;
    logic strap_en = 1, reg_en = 0, route_sel = 0, temp_mode = 0;
    logic [7:0] temp_val = 0;
    logic [6:0] prn_seg, alt_seg;
    logic [1:0] prn_dig, alt_dig;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t sb[$];

    always #10 clk = ~clk;

    post_code_display #(.CLK_HZ(CLK_HZ), .SWITCH_HZ(SWITCH_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_data(io_data), .strap_en(strap_en), .reg_en(reg_en),
        .route_sel(route_sel), .temp_mode(temp_mode), .temp_val(temp_val),
        .prn_seg(prn_seg), .prn_dig(prn_dig), .alt_seg(alt_seg), .alt_dig(alt_dig)
    );

    // R3 segment codes, taken from the requirement.
    function automatic logic [6:0] pat(input logic [3:0] n);
        logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                               7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
        return t[n];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input string tag);
        exp_t e;
        e.hi = pat(b[7:4]);
        e.lo = pat(b[3:0]);
        e.route = route_sel;
        e.tag = tag;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1; io_addr = a; io_data = d;
        @(negedge clk);
        io_wr = 0;
    endtask

    // Monitor: wait for each digit on the routed group and compare.
    task automatic grab(input logic route, input logic [1:0] want,
                        output logic [6:0] seg, output int other);
        forever begin
            @(negedge clk);
            if ((route ? alt_dig : prn_dig) == want) break;
        end
        seg = route ? alt_seg : prn_seg;
        other = route ? int'({prn_seg, prn_dig}) : int'({alt_seg, alt_dig});
    endtask

    initial begin
        forever begin
            exp_t e;
            logic [6:0] s;
            int o;
            wait (sb.size() > 0);
            e = sb[0];
            grab(e.route, 2'b10, s, o);
            check({e.tag, " R3 R4 high digit"}, s, e.hi);
            check({e.tag, " R7 other group quiet"}, o, 0);
            grab(e.route, 2'b01, s, o);
            check({e.tag, " R3 R4 low digit"}, s, e.lo);
            check({e.tag, " R7 other group quiet"}, o, 0);
            void'(sb.pop_front());
        end
    end

    // Driver.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9 first phase is high nibble", prn_dig, 2'b10);
        push(8'h00, "R9 reset shows 00");
        io_write(16'h0080, 8'hA5); push(8'hA5, "R1 capture A5");
        io_write(16'h0081, 8'h12); push(8'hA5, "R2 addr 0081 ignored");
        io_write(16'h0180, 8'h33); push(8'hA5, "R2 addr 0180 ignored");
        io_write(16'h0080, 8'h3C); push(8'h3C, "R1 capture 3C");
        io_write(16'h0080, 8'h9E); push(8'h9E, "R1 capture 9E");
        io_write(16'h0080, 8'h48); push(8'h48, "R1 capture 48");
        io_write(16'h0080, 8'hD0); push(8'hD0, "R1 capture D0");
        io_write(16'h0080, 8'h12); push(8'h12, "R1 capture 12");
        io_write(16'h0080, 8'hF6); push(8'hF6, "R1 capture F6");
        io_write(16'h0080, 8'h7B); push(8'h7B, "R1 capture 7B");
        @(negedge clk); route_sel = 1;
        push(8'h7B, "R7 alternate route");
        @(negedge clk); temp_mode = 1; temp_val = 8'h2E;
        push(8'h2E, "R8 temperature shown");
        @(negedge clk); temp_mode = 0; route_sel = 0;
        push(8'h7B, "R8 back to code");
        // R6 disabled: every output stays low; a write is still captured.
        @(negedge clk); strap_en = 0;
        io_write(16'h0080, 8'h55);
        begin
            int bad = 0;
            for (int i = 0; i < 2 * DIV + 2; i++) begin
                @(negedge clk);
                if ({prn_seg, prn_dig, alt_seg, alt_dig} != 0) bad++;
            end
            check("R6 disabled outputs low (bad cycles)", bad, 0);
        end
        @(negedge clk); reg_en = 1;
        push(8'h55, "R6 register enable");
        // R4 R5 phase timing: one blank cycle then DIV-1 lit cycles.
        begin
            int lit = 0;
            int blanks = 0;
            while (prn_dig != 2'b00) @(negedge clk);
            while (prn_dig == 2'b00) begin blanks++; @(negedge clk); end
            while (prn_dig != 2'b00) begin lit++; @(negedge clk); end
            check("R5 blank cycles per switch", blanks, 1);
            check("R4 lit cycles per phase", lit, DIV - 1);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule